// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block is a one-word-per-line, direct-mapped cache placed between a processor request port and a slower main-memory port. A processor access is split into a tag, a line index and a byte offset. The index picks exactly one line. The access hits only when that line is valid and its stored tag matches. Read hits return data with no memory traffic. Every store is written through to memory. A miss of either kind stalls the processor. The controller fetches the word from memory, fills the line and then restarts the lookup, so the access finishes as a hit. A write miss therefore performs a memory read and then a memory write.

Both ports follow valid/ready rules. On the processor side, a request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. Ready is high only while the controller is idle, so back-pressure lasts from acceptance until the response. Each accepted request gets exactly one single-cycle `cpu_resp_valid` pulse, and there is no way to stall the response. On the memory side, the controller raises `mem_req_valid` and holds address, direction and write data stable until memory returns `mem_req_ready`. Memory may take any number of cycles to do so. For a read, `mem_rdata` must be valid in the same cycle as `mem_req_ready`.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset `cpu_req_ready` is 1, `mem_req_valid` is 0, `cpu_resp_valid` is 0, and every line is invalid, so the first access to any line misses.
- R2: The line index is address bits [11:2] and the tag is bits [31:12]. Bits [1:0] are ignored. A hit needs a set valid bit and an equal tag. Two addresses with the same index but different tags evict each other.
- R3: A read hit produces `cpu_resp_valid` on the second rising edge after acceptance, carrying the line data, and issues no memory request.
- R4: A read miss issues exactly one memory read of the word-aligned address (bits [1:0] zero), returns the memory word, and leaves the line filled so the next read to that address hits.
- R5: A write hit updates the line and issues exactly one memory write with the word-aligned address and the store data, and no memory read.
- R6: A write miss issues one memory read followed by one memory write. A later read of that address hits and returns the stored data.
- R7: `cpu_req_ready` is 0 from the cycle after acceptance through the response cycle, and requests offered in that window are not taken.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with address, `mem_req_we` and `mem_req_wdata` unchanged.
- R9: Each accepted request yields exactly one `cpu_resp_valid` pulse, during which no memory request is active. For writes, `cpu_resp_rdata` echoes the store data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request offered |
| cpu_req_ready | output | 1 | Controller idle and able to take a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 32 | Load data, or the store data for a write |
| mem_req_valid | output | 1 | Memory transaction requested |
| mem_req_ready | input | 1 | Memory accepts or completes the transaction |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Write-through data |
| mem_rdata | input | 32 | Read data, valid with mem_req_ready |

## Verification
The hardest case to reach from the ports is a write miss that lands on a line already holding another tag. That case requires the fetch, refill, restart and write-through to happen in order, under uneven memory latency. The bench first fills all 1024 lines with tag 0 and then stores to tag 1 at every index, so each store displaces a valid line. The memory model varies its acknowledge delay from 0 to 3 cycles and records the order of its transactions. A final sweep reads tag 0 again to show the conflict evicted the old line without changing memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COMPARE = 3'd1,
    ST_FETCH   = 3'd2,
    ST_WMEM    = 3'd3,
    ST_DONE    = 3'd4
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 1024,
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  assign hit = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);

  // An invalid line can never be the one that matches.
  AST_NO_HIT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q[lk_idx] |-> !hit); // R2
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES  = 1024,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] words [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              hit,
  input  logic [DATA_W-1:0] line_rdata,
  output logic              fill_en,
  output logic              dat_we,
  output logic [DATA_W-1:0] dat_wdata
);
  dmc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept;

  assign accept = cpu_req_valid && (state_q == ST_IDLE);
  assign lk_idx = addr_q[OFF_W +: IDX_W];
  assign lk_tag = addr_q[ADDR_W-1 -: TAG_W];

  always_comb begin
    state_d   = state_q;
    fill_en   = 1'b0;
    dat_we    = 1'b0;
    dat_wdata = wdata_q;
    unique case (state_q)
      ST_IDLE:    if (cpu_req_valid) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (!hit) state_d = ST_FETCH;
        else if (we_q) begin
          dat_we  = 1'b1;
          state_d = ST_WMEM;
        end else state_d = ST_DONE;
      end
      ST_FETCH: if (mem_req_ready) begin
        fill_en   = 1'b1;
        dat_we    = 1'b1;
        dat_wdata = mem_rdata;
        state_d   = ST_COMPARE;
      end
      ST_WMEM:  if (mem_req_ready) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= cpu_req_addr;
        we_q    <= cpu_req_we;
        wdata_q <= cpu_req_wdata;
      end
      if (state_q == ST_COMPARE && hit)
        rdata_q <= we_q ? wdata_q : line_rdata;
    end
  end

  assign cpu_req_ready  = (state_q == ST_IDLE);
  assign cpu_resp_valid = (state_q == ST_DONE);
  assign cpu_resp_rdata = rdata_q;
  assign mem_req_valid  = (state_q == ST_FETCH) || (state_q == ST_WMEM);
  assign mem_req_we     = (state_q == ST_WMEM);
  assign mem_req_addr   = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata  = wdata_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready); // R7
  AST_REFILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMPARE) && ($past(state_q) == ST_FETCH) |-> hit); // R4
  AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> !mem_req_valid && !cpu_req_ready); // R9
  AST_WRITE_ONLY_FOR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> we_q); // R5
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              hit;
  logic [DATA_W-1:0] line_rdata;
  logic              fill_en;
  logic              dat_we;
  logic [DATA_W-1:0] dat_wdata;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit), .line_rdata(line_rdata),
    .fill_en(fill_en), .dat_we(dat_we), .dat_wdata(dat_wdata)
  );

  dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit),
    .fill_en(fill_en), .fill_idx(lk_idx), .fill_tag(lk_tag)
  );

  dmc_data_store #(.LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rd_idx(lk_idx), .rd_data(line_rdata),
    .wr_en(dat_we), .wr_idx(lk_idx), .wr_data(dat_wdata)
  );
endmodule

// File: tb/dm_wt_cache_tb_top.sv
module dm_wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_resp_valid;
  logic [31:0] cpu_resp_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  dm_wt_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata)
  );

  int nvec = 0, nerr = 0, done = 0;
  int nrd = 0, nwr = 0, nresp = 0, nacc = 0, hold_err = 0, bad_align = 0;
  logic [1:0]  seq = 2'b00;      // last two memory ops, 1 = write
  logic [31:0] last_waddr = '0, last_wdata = '0;
  logic [31:0] model [8192];
  int lat_cfg = 0, lat_cnt = 0;
  logic        pend = 1'b0, pv_we = 1'b0;
  logic [31:0] pv_addr = '0, pv_wdata = '0;
  logic        hs_we = 1'b0;
  logic [31:0] hs_addr = '0, hs_wdata = '0;

  function automatic logic [31:0] init_word(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_9E37);
  endfunction

  function automatic logic [31:0] mk_addr(input int tag, input int idx);
    return {tag[19:0], idx[9:0], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: variable acknowledge delay 0..3 cycles, driven at falling edges.
  always @(negedge clk) begin
    if (mem_req_ready) begin
      mem_req_ready = 1'b0;
      if (hs_we) begin
        model[hs_addr[14:2]] = hs_wdata;
        nwr++; seq = {seq[0], 1'b1};
        last_waddr = hs_addr; last_wdata = hs_wdata;
      end else begin
        nrd++; seq = {seq[0], 1'b0};
      end
      pend = 1'b0;
    end else if (mem_req_valid) begin
      if (mem_req_addr[1:0] != 2'b00) bad_align++;
      if (pend && (mem_req_addr != pv_addr || mem_req_we != pv_we || mem_req_wdata != pv_wdata))
        hold_err++;
      if (lat_cnt >= lat_cfg) begin
        mem_req_ready = 1'b1;
        hs_we = mem_req_we; hs_addr = mem_req_addr; hs_wdata = mem_req_wdata;
        mem_rdata = model[mem_req_addr[14:2]];
        lat_cnt = 0; lat_cfg = (lat_cfg + 1) % 4;
        pend = 1'b0;
      end else begin
        lat_cnt++;
        pend = 1'b1; pv_addr = mem_req_addr; pv_we = mem_req_we; pv_wdata = mem_req_wdata;
      end
    end else begin
      if (pend) hold_err++;
      pend = 1'b0;
    end
    if (cpu_resp_valid) nresp++;
  end

  task automatic do_access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, output int dr, output int dw,
                           output int lat, output int busy);
    int r0, w0;
    r0 = nrd; w0 = nwr;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    @(posedge clk);
    nacc++;
    @(negedge clk);
    // keep offering a different request during the busy window: it must be ignored
    cpu_req_we = 1'b1; cpu_req_addr = 32'hFFFF_FFFC; cpu_req_wdata = 32'hDEAD_BEEF;
    lat = 1; busy = 0;
    while (!cpu_resp_valid) begin
      if (cpu_req_ready) busy++;
      @(negedge clk);
      lat++;
    end
    if (cpu_req_ready) busy++;
    cpu_req_valid = 1'b0;
    rd = cpu_resp_rdata;
    #1;
    dr = nrd - r0; dw = nwr - w0;
  endtask

  initial begin
    logic [31:0] rd;
    int dr, dw, lat, busy;
    for (int i = 0; i < 8192; i++) model[i] = init_word(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cpu_req_ready == 1'b1, "R1 ready after reset", {31'd0, cpu_req_ready}, 32'd1);
    chk(mem_req_valid == 1'b0, "R1 no mem request in reset", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready && !mem_req_valid && !cpu_resp_valid, "R1 idle after release",
        {29'd0, cpu_req_ready, mem_req_valid, cpu_resp_valid}, 32'd4);

    // Phase A: first read of every line misses (R1, R4)
    for (int i = 0; i < 1024; i++) begin
      do_access(1'b0, mk_addr(0, i), '0, rd, dr, dw, lat, busy);
      chk(rd == init_word(i), "R4 miss data", rd, init_word(i));
      chk(dr == 1 && dw == 0, "R1 R4 first access misses once", dr * 16 + dw, 32'h10);
      chk(busy == 0, "R7 ready low while busy", busy, 0);
    end
    // Phase B: rereads hit in two cycles (R3)
    for (int i = 0; i < 1024; i++) begin
      do_access(1'b0, mk_addr(0, i), '0, rd, dr, dw, lat, busy);
      chk(rd == init_word(i), "R3 hit data", rd, init_word(i));
      chk(dr == 0 && dw == 0 && lat == 2, "R3 hit timing no mem", lat * 256 + dr * 16 + dw, 32'h200);
    end
    // Phase C: write misses onto lines holding tag 0 (R6, R2 conflict)
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] v;
      v = 32'hC000_0000 + i * 7;
      do_access(1'b1, mk_addr(1, i), v, rd, dr, dw, lat, busy);
      chk(dr == 1 && dw == 1 && seq == 2'b01, "R6 read then write",
          {dr[7:0], dw[7:0], 14'd0, seq}, 32'h0101_0001);
      chk(last_waddr == mk_addr(1, i) && last_wdata == v, "R6 write-through value", last_wdata, v);
      chk(rd == v, "R9 store echo", rd, v);
      chk(busy == 0, "R7 ready low while busy", busy, 0);
    end
    // Phase D: stored words now hit (R6)
    for (int i = 0; i < 1024; i++) begin
      do_access(1'b0, mk_addr(1, i), '0, rd, dr, dw, lat, busy);
      chk(rd == 32'hC000_0000 + i * 7 && dr == 0 && lat == 2, "R6 stored word hits",
          rd, 32'hC000_0000 + i * 7);
    end
    // Phase E: write hits (R5)
    for (int i = 0; i < 1024; i += 3) begin
      logic [31:0] v;
      v = ~(32'h0BAD_0000 + i);
      do_access(1'b1, mk_addr(1, i) | 32'd1, v, rd, dr, dw, lat, busy);
      chk(dr == 0 && dw == 1, "R5 write hit mem ops", dr * 16 + dw, 32'h01);
      chk(last_waddr == mk_addr(1, i) && last_wdata == v, "R5 write-through addr/data",
          last_waddr, mk_addr(1, i));
      do_access(1'b0, mk_addr(1, i), '0, rd, dr, dw, lat, busy);
      chk(rd == v && dr == 0, "R5 line updated", rd, v);
    end
    // Phase F: tag 0 evicted, memory copy intact (R2)
    for (int i = 0; i < 1024; i++) begin
      do_access(1'b0, mk_addr(0, i), '0, rd, dr, dw, lat, busy);
      chk(rd == init_word(i) && dr == 1 && dw == 0, "R2 conflict eviction", rd, init_word(i));
    end
    // Phase G: byte offset ignored (R2)
    for (int i = 0; i < 1024; i += 5) begin
      do_access(1'b0, mk_addr(0, i) | 32'd3, '0, rd, dr, dw, lat, busy);
      chk(rd == init_word(i) && dr == 0 && lat == 2, "R2 offset ignored", rd, init_word(i));
    end
    repeat (3) @(negedge clk);
    chk(hold_err == 0, "R8 request held stable", hold_err, 0);
    chk(bad_align == 0, "R4 word-aligned memory address", bad_align, 0);
    chk(nresp == nacc, "R9 one response per request", nresp, nacc);
    chk(nwr == 1024 + 342, "R7 busy-window offers ignored", nwr, 1024 + 342);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nerr++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule